// File: doc/BRIEF.md
# Integer ALU with T Flag

This block is the integer arithmetic and logic datapath for a 32-bit core that keeps a single condition bit, T, in place of a full flag set. Each cycle it takes two register operands, an 8-bit immediate, the current T bit and an operation code. It computes one operation: add or subtract, with or without a carry, borrow or overflow into T, negate, signed and unsigned compares, decrement-and-test, bitwise logic with a test variant, or byte and word sign or zero extension.

It returns the result word with a register write enable, and the new T value with a T write enable. Each operation follows its own rule for whether it writes the register, writes T, or both. The caller keeps its stored T whenever `t_we` is low. The outputs are registered, so they show the operation that was presented one rising edge earlier.

For operations that take an immediate and a register, the caller places that register (normally register zero) on `a_val`.

Top module: `tflag_alu`

## Requirements
- R1: While `rst_n` is low, `res_out`, `res_we`, `t_out` and `t_we` are all 0.
- R2: The outputs show the operation, operands and T presented before the most recent rising edge. There is exactly one cycle of latency.
- R3: ADDC (1) writes a+b+T. SUBC (4) writes a−b−T. NEGC (7) writes 0−b−T. ADDC puts the carry out into T. SUBC and NEGC put the borrow out into T.
- R4: ADDV (2) writes a+b and SUBV (5) writes a−b. Each sets T to 1 exactly when the signed result overflows.
- R5: The register compares set T and write no register, with `res_out` 0. They are CMPEQ (11, a=b), CMPHS (12, unsigned a≥b), CMPGE (13, signed a≥b), CMPHI (14, unsigned a>b), CMPGT (15, signed a>b) and CMPEQI (19, a equal to the sign-extended immediate).
- R6: CMPPZ (16) sets T when a is signed ≥0. CMPPL (17) sets T when a is signed >0. Neither writes a register.
- R7: CMPSTR (18) sets T when any of the four byte lanes of a equals the same lane of b. It writes no register.
- R8: DT (8) writes a−1 and sets T to 1 exactly when that new value is zero.
- R9: TST (27) computes a AND b, and TSTI (28) computes a AND the zero-extended immediate. Each sets T when the AND is zero and writes no register.
- R10: The immediate is sign-extended for ADDI (9, a+imm) and MOVI (10, imm), and also for CMPEQI. It is zero-extended for ANDI (24), ORI (25), XORI (26) and TSTI. As a result, ANDI always clears bits 31:8.
- R11: ADD (0), SUB (3), NEG (6), AND (20), OR (21), XOR (22), NOT (23, ~b), ADDI, MOVI, ANDI, ORI, XORI and the extensions write the register and leave T alone. For these, `t_we` is 0 and `t_out` equals the T that was presented.
- R12: EXTSB (29) and EXTSW (30) sign-extend the low byte or low half-word of b. EXTUB (31) and EXTUW (32) zero-extend them.
- R13: Codes 33 to 63 write nothing: `res_we` and `t_we` are 0 and `res_out` is 0. For every op with `t_we` 0, `t_out` equals the T presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 6 | Operation code |
| a_val | input | 32 | First register operand (destination register value) |
| b_val | input | 32 | Second register operand |
| imm8 | input | 8 | Immediate field |
| t_in | input | 1 | Current T bit |
| res_out | output | 32 | Result word |
| res_we | output | 1 | Result is to be written to the register |
| t_out | output | 1 | New T value |
| t_we | output | 1 | T is to be written |

## Verification
Many operations write the result word and T in the same cycle. Examples are the carry, borrow and overflow arithmetic and decrement-and-test, where both values come from one adder pass. The bench provokes these with operands at the carry and sign boundaries (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF), with T both 0 and 1. Each scoreboard entry holds the result, both enables and T together, so a single-cycle check judges the register write and the flag write jointly against a reference model written from the requirements.

// File: rtl/tfalu_pkg.sv
package tfalu_pkg;

    parameter int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 6'd0,
        OP_ADDC   = 6'd1,
        OP_ADDV   = 6'd2,
        OP_SUB    = 6'd3,
        OP_SUBC   = 6'd4,
        OP_SUBV   = 6'd5,
        OP_NEG    = 6'd6,
        OP_NEGC   = 6'd7,
        OP_DT     = 6'd8,
        OP_ADDI   = 6'd9,
        OP_MOVI   = 6'd10,
        OP_CMPEQ  = 6'd11,
        OP_CMPHS  = 6'd12,
        OP_CMPGE  = 6'd13,
        OP_CMPHI  = 6'd14,
        OP_CMPGT  = 6'd15,
        OP_CMPPZ  = 6'd16,
        OP_CMPPL  = 6'd17,
        OP_CMPSTR = 6'd18,
        OP_CMPEQI = 6'd19,
        OP_AND    = 6'd20,
        OP_OR     = 6'd21,
        OP_XOR    = 6'd22,
        OP_NOT    = 6'd23,
        OP_ANDI   = 6'd24,
        OP_ORI    = 6'd25,
        OP_XORI   = 6'd26,
        OP_TST    = 6'd27,
        OP_TSTI   = 6'd28,
        OP_EXTSB  = 6'd29,
        OP_EXTSW  = 6'd30,
        OP_EXTUB  = 6'd31,
        OP_EXTUW  = 6'd32
    } alu_op_e;

    localparam int LAST_OP = 32;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out,
    output logic             v_out
);
    logic [WIDTH:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};
        sum_out  = wide_sum[WIDTH-1:0];
        c_out    = wide_sum[WIDTH];
        // Signed overflow: both operands share a sign that the sum does not.
        v_out    = (x_in[WIDTH-1] == y_in[WIDTH-1]) &&
                   (wide_sum[WIDTH-1] != x_in[WIDTH-1]);
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             is_eq,
    output logic             is_hs,
    output logic             is_ge,
    output logic             is_hi,
    output logic             is_gt,
    output logic             is_pz,
    output logic             is_pl,
    output logic             lane_hit
);
    localparam int LANES = WIDTH / 8;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (lhs[g*8 +: 8] == rhs[g*8 +: 8]);
    end

    always_comb begin
        is_eq    = (lhs == rhs);
        is_hs    = (lhs >= rhs);
        is_hi    = (lhs >  rhs);
        is_ge    = ($signed(lhs) >= $signed(rhs));
        is_gt    = ($signed(lhs) >  $signed(rhs));
        is_pz    = ~lhs[WIDTH-1];
        is_pl    = ~lhs[WIDTH-1] && (lhs != '0);
        lane_hit = |lane_eq;
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import tfalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] bits_out
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        unique case (op)
            OP_AND, OP_ANDI, OP_TST, OP_TSTI: bits_out = lhs & rhs;
            OP_OR,  OP_ORI:                   bits_out = lhs | rhs;
            OP_XOR, OP_XORI:                  bits_out = lhs ^ rhs;
            OP_NOT:   bits_out = ~rhs;
            OP_EXTSB: bits_out = {{(WIDTH-BYTE_W){rhs[BYTE_W-1]}}, rhs[BYTE_W-1:0]};
            OP_EXTSW: bits_out = {{(WIDTH-HALF_W){rhs[HALF_W-1]}}, rhs[HALF_W-1:0]};
            OP_EXTUB: bits_out = {{(WIDTH-BYTE_W){1'b0}}, rhs[BYTE_W-1:0]};
            OP_EXTUW: bits_out = {{(WIDTH-HALF_W){1'b0}}, rhs[HALF_W-1:0]};
            default:  bits_out = '0;
        endcase
    end
endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
    import tfalu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  logic [IMM_W-1:0] imm8,
    input  logic             t_in,
    output logic [WIDTH-1:0] res_out,
    output logic             res_we,
    output logic             t_out,
    output logic             t_we
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             res_we;
        logic             t_val;
        logic             t_we;
    } alu_out_s;

    alu_out_s out_d, out_q;
    alu_op_e  op;

    logic [WIDTH-1:0] imm_sx, imm_zx;
    logic [WIDTH-1:0] add_x, add_y, add_sum;
    logic             add_ci, add_co, add_ov;
    logic [WIDTH-1:0] cmp_rhs, bit_rhs, bit_res;
    logic is_eq, is_hs, is_ge, is_hi, is_gt, is_pz, is_pl, lane_hit;

    assign op     = alu_op_e'(op_sel);
    assign imm_sx = {{(WIDTH-IMM_W){imm8[IMM_W-1]}}, imm8};
    assign imm_zx = {{(WIDTH-IMM_W){1'b0}}, imm8};

    // Operand steering for the shared adder.
    always_comb begin
        add_x  = a_val;
        add_y  = b_val;
        add_ci = 1'b0;
        unique case (op)
            OP_ADDC:          add_ci = t_in;
            OP_SUB, OP_SUBV:  begin add_y = ~b_val; add_ci = 1'b1;  end
            OP_SUBC:          begin add_y = ~b_val; add_ci = ~t_in; end
            OP_NEG:           begin add_x = '0; add_y = ~b_val; add_ci = 1'b1;  end
            OP_NEGC:          begin add_x = '0; add_y = ~b_val; add_ci = ~t_in; end
            OP_DT:            add_y = '1;
            OP_ADDI:          add_y = imm_sx;
            default:          ;
        endcase
    end

    assign cmp_rhs = (op == OP_CMPEQI) ? imm_sx : b_val;
    assign bit_rhs = (op inside {OP_ANDI, OP_ORI, OP_XORI, OP_TSTI}) ? imm_zx : b_val;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x_in(add_x), .y_in(add_y), .c_in(add_ci),
        .sum_out(add_sum), .c_out(add_co), .v_out(add_ov)
    );

    alu_cmp #(.WIDTH(WIDTH)) u_cmp (
        .lhs(a_val), .rhs(cmp_rhs),
        .is_eq(is_eq), .is_hs(is_hs), .is_ge(is_ge), .is_hi(is_hi),
        .is_gt(is_gt), .is_pz(is_pz), .is_pl(is_pl), .lane_hit(lane_hit)
    );

    alu_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op(op), .lhs(a_val), .rhs(bit_rhs), .bits_out(bit_res)
    );

    // Next-state: per-operation write rules for the register and for T.
    always_comb begin
        out_d = '{res: '0, res_we: 1'b0, t_val: t_in, t_we: 1'b0};
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG, OP_ADDI: begin
                out_d.res = add_sum; out_d.res_we = 1'b1;
            end
            OP_ADDC: begin
                out_d.res = add_sum; out_d.res_we = 1'b1;
                out_d.t_val = add_co; out_d.t_we = 1'b1;
            end
            OP_SUBC, OP_NEGC: begin
                out_d.res = add_sum; out_d.res_we = 1'b1;
                out_d.t_val = ~add_co; out_d.t_we = 1'b1;
            end
            OP_ADDV, OP_SUBV: begin
                out_d.res = add_sum; out_d.res_we = 1'b1;
                out_d.t_val = add_ov; out_d.t_we = 1'b1;
            end
            OP_DT: begin
                out_d.res = add_sum; out_d.res_we = 1'b1;
                out_d.t_val = (add_sum == '0); out_d.t_we = 1'b1;
            end
            OP_MOVI: begin
                out_d.res = imm_sx; out_d.res_we = 1'b1;
            end
            OP_CMPEQ, OP_CMPEQI: begin out_d.t_val = is_eq;    out_d.t_we = 1'b1; end
            OP_CMPHS:            begin out_d.t_val = is_hs;    out_d.t_we = 1'b1; end
            OP_CMPGE:            begin out_d.t_val = is_ge;    out_d.t_we = 1'b1; end
            OP_CMPHI:            begin out_d.t_val = is_hi;    out_d.t_we = 1'b1; end
            OP_CMPGT:            begin out_d.t_val = is_gt;    out_d.t_we = 1'b1; end
            OP_CMPPZ:            begin out_d.t_val = is_pz;    out_d.t_we = 1'b1; end
            OP_CMPPL:            begin out_d.t_val = is_pl;    out_d.t_we = 1'b1; end
            OP_CMPSTR:           begin out_d.t_val = lane_hit; out_d.t_we = 1'b1; end
            OP_TST, OP_TSTI: begin
                out_d.t_val = (bit_res == '0); out_d.t_we = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI, OP_XORI,
            OP_EXTSB, OP_EXTSW, OP_EXTUB, OP_EXTUW: begin
                out_d.res = bit_res; out_d.res_we = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_out = out_q.res;
    assign res_we  = out_q.res_we;
    assign t_out   = out_q.t_val;
    assign t_we    = out_q.t_we;

    // Compares never request a register write (R5).
    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel inside {OP_CMPEQ, OP_CMPHS, OP_CMPGE, OP_CMPHI, OP_CMPGT, OP_CMPEQI})
        |=> (!res_we && t_we));

    // Decrement-and-test flag agrees with the written value (R8).
    assert_dt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_DT) |=> (t_we && res_we && (t_out == (res_out == '0))));

    // Logical immediate AND clears the upper bits (R10).
    assert_andi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ANDI) |=> (res_we && (res_out[WIDTH-1:IMM_W] == '0)));

    // T-neutral operations pass T through untouched (R11).
    assert_t_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel inside {OP_ADD, OP_SUB, OP_NEG, OP_AND, OP_OR, OP_XOR, OP_NOT,
                        OP_EXTSB, OP_EXTSW, OP_EXTUB, OP_EXTUW})
        |=> (!t_we && res_we && (t_out == $past(t_in))));

    // Equal operands always share a byte lane (R7).
    assert_str_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_val == cmp_rhs) |-> (lane_hit && is_eq && is_hs && is_ge));

    // Undefined codes write nothing (R13).
    assert_undef_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_W'(LAST_OP)) |=> (!res_we && !t_we && (res_out == '0)));

endmodule

// File: tb/tflag_alu_bench.sv
`timescale 1ns/1ps
module tflag_alu_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    op_sel = '0;
    logic [W-1:0]  a_val = '0, b_val = '0;
    logic [7:0]    imm8 = '0;
    logic          t_in = 1'b0;
    logic [W-1:0]  res_out;
    logic          res_we, t_out, t_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [W-1:0] res;
        logic         we;
        logic         t;
        logic         twe;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tflag_alu u_tflag_alu (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .a_val(a_val), .b_val(b_val),
        .imm8(imm8), .t_in(t_in), .res_out(res_out), .res_we(res_we),
        .t_out(t_out), .t_we(t_we)
    );

    // Reference model written from the requirement list.
    function automatic exp_t model(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [7:0] im, input logic t);
        exp_t e;
        longint sa, sb, ss;
        logic [W-1:0] sx, zx;
        logic [W:0] wide;
        sx = {{24{im[7]}}, im};
        zx = {24'h0, im};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e.res = '0; e.we = 0; e.t = t; e.twe = 0; e.tag = "R13";
        case (op)
            0:  begin e.res = a + b; e.we = 1; e.tag = "R11"; end
            1:  begin wide = {1'b0,a} + {1'b0,b} + t; e.res = wide[W-1:0]; e.we = 1;
                      e.t = wide[W]; e.twe = 1; e.tag = "R3"; end
            2:  begin e.res = a + b; e.we = 1; ss = sa + sb;
                      e.t = (ss > 64'sd2147483647) || (ss < -64'sd2147483648); e.twe = 1; e.tag = "R4"; end
            3:  begin e.res = a - b; e.we = 1; e.tag = "R11"; end
            4:  begin e.res = a - b - t; e.we = 1;
                      e.t = ({1'b0,a} < ({1'b0,b} + t)); e.twe = 1; e.tag = "R3"; end
            5:  begin e.res = a - b; e.we = 1; ss = sa - sb;
                      e.t = (ss > 64'sd2147483647) || (ss < -64'sd2147483648); e.twe = 1; e.tag = "R4"; end
            6:  begin e.res = -b; e.we = 1; e.tag = "R11"; end
            7:  begin e.res = 0 - b - t; e.we = 1;
                      e.t = (({1'b0,b} + t) != 0); e.twe = 1; e.tag = "R3"; end
            8:  begin e.res = a - 1; e.we = 1; e.t = (a == 1); e.twe = 1; e.tag = "R8"; end
            9:  begin e.res = a + sx; e.we = 1; e.tag = "R10"; end
            10: begin e.res = sx; e.we = 1; e.tag = "R10"; end
            11: begin e.t = (a == b); e.twe = 1; e.tag = "R5"; end
            12: begin e.t = (a >= b); e.twe = 1; e.tag = "R5"; end
            13: begin e.t = (sa >= sb); e.twe = 1; e.tag = "R5"; end
            14: begin e.t = (a > b); e.twe = 1; e.tag = "R5"; end
            15: begin e.t = (sa > sb); e.twe = 1; e.tag = "R5"; end
            16: begin e.t = (sa >= 0); e.twe = 1; e.tag = "R6"; end
            17: begin e.t = (sa > 0); e.twe = 1; e.tag = "R6"; end
            18: begin e.t = (a[7:0] == b[7:0]) || (a[15:8] == b[15:8]) ||
                            (a[23:16] == b[23:16]) || (a[31:24] == b[31:24]);
                      e.twe = 1; e.tag = "R7"; end
            19: begin e.t = (a == sx); e.twe = 1; e.tag = "R10"; end
            20: begin e.res = a & b; e.we = 1; e.tag = "R11"; end
            21: begin e.res = a | b; e.we = 1; e.tag = "R11"; end
            22: begin e.res = a ^ b; e.we = 1; e.tag = "R11"; end
            23: begin e.res = ~b; e.we = 1; e.tag = "R11"; end
            24: begin e.res = a & zx; e.we = 1; e.tag = "R10"; end
            25: begin e.res = a | zx; e.we = 1; e.tag = "R10"; end
            26: begin e.res = a ^ zx; e.we = 1; e.tag = "R10"; end
            27: begin e.t = ((a & b) == 0); e.twe = 1; e.tag = "R9"; end
            28: begin e.t = ((a & zx) == 0); e.twe = 1; e.tag = "R9"; end
            29: begin e.res = W'($signed(b[7:0])); e.we = 1; e.tag = "R12"; end
            30: begin e.res = W'($signed(b[15:0])); e.we = 1; e.tag = "R12"; end
            31: begin e.res = {24'h0, b[7:0]}; e.we = 1; e.tag = "R12"; end
            32: begin e.res = {16'h0, b[15:0]}; e.we = 1; e.tag = "R12"; end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: present one operation and push its expected outcome.
    task automatic drive(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [7:0] im, input logic t);
        @(negedge clk);
        op_sel = 6'(op); a_val = a; b_val = b; imm8 = im; t_in = t;
        exp_q.push_back(model(op, a, b, im, t));
    endtask

    // Monitor: R2, one edge of latency; each item is judged just after its capture edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (res_out !== e.res || res_we !== e.we || t_out !== e.t || t_we !== e.twe) begin
                    n_bad++;
                    $display("FAIL %s/R2: got res=%h we=%b t=%b twe=%b expected res=%h we=%b t=%b twe=%b",
                             e.tag, res_out, res_we, t_out, t_we, e.res, e.we, e.t, e.twe);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got no completion expected completion");
        finish_run();
    end

    logic [W-1:0] edges [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    initial begin
        // R1: reset holds every output at zero while inputs toggle.
        op_sel = 6'd1; a_val = '1; b_val = '1; t_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (res_out !== '0 || res_we !== 0 || t_out !== 0 || t_we !== 0) begin
            n_bad++;
            $display("FAIL R1: got res=%h we=%b t=%b twe=%b expected all zero",
                     res_out, res_we, t_out, t_we);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Edge operands across every defined op and both T values.
        for (int op = 0; op <= 32; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int t = 0; t < 2; t++)
                        drive(op, edges[i], edges[j], edges[j][7:0] ^ 8'(i * 37), t[0]);

        // R8: decrement reaching zero and wrapping.
        drive(8, 32'h1, 32'h0, 8'h0, 1'b0);
        drive(8, 32'h0, 32'h0, 8'h0, 1'b1);
        // R7: a single matching lane in each position.
        for (int k = 0; k < 4; k++)
            drive(18, 32'h1122_3344, 32'hAAAA_AAAA ^ ((32'hAA ^ ((32'h1122_3344 >> (8*k)) & 32'hFF)) << (8*k)),
                  8'h0, 1'b0);
        // R10: negative immediates for sign-extending ops, high-bit immediates for logic ops.
        drive(9,  32'h10, 32'h0, 8'hFF, 1'b1);
        drive(10, 32'h0, 32'h0, 8'h80, 1'b0);
        drive(19, 32'hFFFF_FF80, 32'h0, 8'h80, 1'b0);
        drive(24, 32'hFFFF_FFFF, 32'h0, 8'h80, 1'b1);
        drive(28, 32'hFFFF_FF00, 32'h0, 8'hFF, 1'b0);
        // R13: undefined codes.
        for (int op = 33; op < 64; op += 5)
            drive(op, 32'h1234_5678, 32'h9ABC_DEF0, 8'h55, op[0]);

        // Random operands for every op.
        for (int r = 0; r < 40; r++)
            for (int op = 0; op <= 33; op++)
                drive(op, $urandom(), $urandom(), 8'($urandom()), 1'($urandom()));

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule